// File: doc/BRIEF.md
# Frame Length Limit Enforcer

This block runs beside the transmit and receive data paths of a network MAC and holds every frame to a programmable byte ceiling. On the transmit side it counts the bytes fetched from the system bus for the frame in progress. On the receive side it counts the bytes arriving from the wire. Both sides use the same ceiling value. Bytes up to and including that value are allowed, and the first byte beyond it counts as an overrun.

The two directions react to an overrun in different ways. On transmit, the block raises a halt to the descriptor engine and sets a sticky interrupt flag. The halt holds until software issues a restart pulse. On receive, nothing stops. The memory write gate closes for the rest of the frame, and the status word for that frame carries a length-error bit. The frame after it is counted and written normally.

Top module: `frame_len_guard`

## Requirements
- R1: After reset, `tx_halt`, `irq_len_err`, `rx_sts_vld`, `rx_sts_len_err` and `rx_wr_en` are all 0.
- R2: A transmit byte whose position in its frame (the byte with `tx_sof` is position 1) is at most `max_len` never halts. The first transmit byte at position `max_len`+1 sets `tx_halt` on the next clock edge.
- R3: Once `tx_halt` is 1, it stays 1 and transmit byte strobes are ignored until a `tx_restart` pulse. The restart clears the halt on the next edge and also clears the transmit byte count.
- R4: `irq_len_err` is set in the same cycle as `tx_halt` on a transmit overrun. It stays 1, even through `tx_restart`, until an `irq_clr` strobe. If a new overrun and `irq_clr` arrive in the same cycle, the flag stays set.
- R5: `rx_wr_en` is a combinational gate. It is 1 in the same cycle as a receive byte strobe whose position in its frame is at most `max_len`, and 0 otherwise.
- R6: One cycle after a receive byte carrying `rx_eof`, `rx_sts_vld` is 1 for exactly one cycle. At the same time, `rx_sts_len_err` is 1 if any byte of that frame lay beyond `max_len`, and 0 if none did.
- R7: A receive overrun never blocks later frames. The next frame's bytes up to `max_len` are written, and its status is reported on its own.
- R8: Each direction's byte count restarts at position 1 on a byte carrying its start-of-frame marker. Frames that are each within the limit never accumulate into an overrun.
- R9: With `max_len` = 0, every byte is beyond the limit. No receive byte is written, and the first transmit byte halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_len | input | LEN_W (11) | Largest allowed frame length in bytes |
| tx_byte_vld | input | 1 | One transmit byte fetched this cycle |
| tx_sof | input | 1 | Qualifies tx_byte_vld: first byte of a frame |
| tx_eof | input | 1 | Qualifies tx_byte_vld: last byte of a frame |
| tx_restart | input | 1 | Software restart pulse for the transmit engine |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_len_err |
| tx_halt | output | 1 | Halt to the transmit descriptor engine |
| irq_len_err | output | 1 | Sticky transmit length-error interrupt flag |
| rx_byte_vld | input | 1 | One receive byte from the wire this cycle |
| rx_sof | input | 1 | Qualifies rx_byte_vld: first byte of a frame |
| rx_eof | input | 1 | Qualifies rx_byte_vld: last byte of a frame |
| rx_wr_en | output | 1 | Permits the memory write of the current receive byte |
| rx_sts_vld | output | 1 | One-cycle pulse: receive frame status is valid |
| rx_sts_len_err | output | 1 | Receive frame length-error status bit |

## Verification
Transmit frames are sent at exactly the limit, one byte past it, and as back-to-back short frames. Together these separate an off-by-one comparison from a counter that fails to restart on the start marker. Bytes are also driven while the engine is halted, with and without the clear strobe, which shows whether the halt and the interrupt flag are released independently. Receive frames are sent below, at and above the limit, as single-byte frames and with a zero limit. A scoreboard queue pairs each frame's expected status with its pulse, so a lost, extra or misordered status pulse shows up, as does a gate that stays closed after an overrun.

// File: rtl/fle_pkg.sv
package fle_pkg;
    localparam int DEF_LEN_W = 11;

    typedef enum logic [1:0] {
        BYTE_NONE = 2'd0,
        BYTE_IN   = 2'd1,
        BYTE_OVER = 2'd2
    } byte_class_e;
endpackage

// File: rtl/frame_byte_counter.sv
module frame_byte_counter
    import fle_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             vld,
    input  logic             sof,
    input  logic [LEN_W-1:0] max_len,
    output byte_class_e      cls
);
    localparam int CW = LEN_W + 1;
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t    st_d, st_q;
    logic [CW-1:0] pos;

    always_comb begin
        st_d = st_q;
        if (sof)
            pos = CNT_ONE;
        else if (st_q.cnt == CNT_TOP)
            pos = CNT_TOP;
        else
            pos = st_q.cnt + CNT_ONE;

        if (!vld)
            cls = BYTE_NONE;
        else if (pos > {1'b0, max_len})
            cls = BYTE_OVER;
        else
            cls = BYTE_IN;

        if (clr)
            st_d.cnt = '0;
        else if (vld)
            st_d.cnt = pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    a_r8_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && sof && !clr) |=> (st_q.cnt == CNT_ONE));
endmodule

// File: rtl/tx_len_guard.sv
module tx_len_guard
    import fle_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] max_len,
    input  logic             byte_vld,
    input  logic             sof,
    input  logic             restart,
    input  logic             irq_clr,
    output logic             halt,
    output logic             irq
);
    typedef struct packed {
        logic halt;
        logic irq;
    } tx_state_t;

    tx_state_t   st_d, st_q;
    byte_class_e cls;
    logic        take;

    assign take = byte_vld && !st_q.halt && !restart;

    frame_byte_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (restart),
        .vld     (take),
        .sof     (sof),
        .max_len (max_len),
        .cls     (cls)
    );

    always_comb begin
        st_d = st_q;
        if (restart)
            st_d.halt = 1'b0;
        else if (cls == BYTE_OVER)
            st_d.halt = 1'b1;

        if (cls == BYTE_OVER)
            st_d.irq = 1'b1;
        else if (irq_clr)
            st_d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign halt = st_q.halt;
    assign irq  = st_q.irq;

    a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !restart) |=> halt);
    a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !halt);
    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    a_r4_irq_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> halt);
endmodule

// File: rtl/rx_len_guard.sv
module rx_len_guard
    import fle_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] max_len,
    input  logic             byte_vld,
    input  logic             sof,
    input  logic             eof,
    output logic             wr_en,
    output logic             sts_vld,
    output logic             sts_err
);
    typedef struct packed {
        logic over;
        logic sts_vld;
        logic sts_err;
    } rx_state_t;

    rx_state_t   st_d, st_q;
    byte_class_e cls;
    logic        prior_over;

    frame_byte_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (1'b0),
        .vld     (byte_vld),
        .sof     (sof),
        .max_len (max_len),
        .cls     (cls)
    );

    always_comb begin
        st_d = st_q;
        prior_over = st_q.over && !sof;
        if (byte_vld)
            st_d.over = prior_over || (cls == BYTE_OVER);
        st_d.sts_vld = byte_vld && eof;
        st_d.sts_err = byte_vld && eof && (prior_over || (cls == BYTE_OVER));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign wr_en   = (cls == BYTE_IN);
    assign sts_vld = st_q.sts_vld;
    assign sts_err = st_q.sts_err;

    a_r5_gate_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> byte_vld);
    a_r6_status_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        sts_vld |-> $past(byte_vld && eof));
    a_r6_err_only_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        sts_err |-> sts_vld);
    a_r7_first_byte_written: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && sof && (max_len != '0)) |-> wr_en);
    a_r9_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (max_len == '0) |-> !wr_en);
endmodule

// File: rtl/frame_len_guard.sv
module frame_len_guard
    import fle_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] max_len,
    input  logic             tx_byte_vld,
    input  logic             tx_sof,
    input  logic             tx_eof,
    input  logic             tx_restart,
    input  logic             irq_clr,
    output logic             tx_halt,
    output logic             irq_len_err,
    input  logic             rx_byte_vld,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic             rx_wr_en,
    output logic             rx_sts_vld,
    output logic             rx_sts_len_err
);
    logic tx_eof_unused;
    assign tx_eof_unused = tx_eof;

    tx_len_guard #(.LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .max_len  (max_len),
        .byte_vld (tx_byte_vld),
        .sof      (tx_sof),
        .restart  (tx_restart),
        .irq_clr  (irq_clr),
        .halt     (tx_halt),
        .irq      (irq_len_err)
    );

    rx_len_guard #(.LEN_W(LEN_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .max_len  (max_len),
        .byte_vld (rx_byte_vld),
        .sof      (rx_sof),
        .eof      (rx_eof),
        .wr_en    (rx_wr_en),
        .sts_vld  (rx_sts_vld),
        .sts_err  (rx_sts_len_err)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_halt && !irq_len_err && !rx_sts_vld));
endmodule

// File: tb/frame_len_guard_test.sv
module frame_len_guard_test;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] max_len = '0;
    logic tx_byte_vld = 0, tx_sof = 0, tx_eof = 0, tx_restart = 0, irq_clr = 0;
    logic rx_byte_vld = 0, rx_sof = 0, rx_eof = 0;
    logic tx_halt, irq_len_err, rx_wr_en, rx_sts_vld, rx_sts_len_err;

    int checks = 0;
    int failures = 0;
    logic exp_q[$];
    bit done = 0;

    always #10 clk = ~clk;

    frame_len_guard #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .max_len(max_len),
        .tx_byte_vld(tx_byte_vld), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_restart(tx_restart), .irq_clr(irq_clr),
        .tx_halt(tx_halt), .irq_len_err(irq_len_err),
        .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_wr_en(rx_wr_en), .rx_sts_vld(rx_sts_vld), .rx_sts_len_err(rx_sts_len_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected status per pulse
    always @(negedge clk) begin
        if (rst_n && rx_sts_vld) begin
            if (exp_q.size() == 0)
                chk(0, "R6 unexpected status pulse", 1, 0);
            else begin
                logic e;
                e = exp_q.pop_front();
                chk(rx_sts_len_err == e, "R6 frame length-error status",
                    int'(rx_sts_len_err), int'(e));
            end
        end
    end

    task automatic send_tx(input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_byte_vld = 1; tx_sof = (i == 0); tx_eof = (i == len - 1);
            #1;
            if (i > 0)
                chk(tx_halt == (i > int'(max_len)), tag, int'(tx_halt),
                    int'(i > int'(max_len)));
        end
        @(negedge clk);
        tx_byte_vld = 0; tx_sof = 0; tx_eof = 0;
        #1 chk(tx_halt == (len > int'(max_len)), tag, int'(tx_halt),
               int'(len > int'(max_len)));
    endtask

    task automatic send_rx(input int len, input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_byte_vld = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            if (i == len - 1) exp_q.push_back(len > int'(max_len));
            #1;
            if (rx_wr_en != ((i + 1) <= int'(max_len))) bad++;
        end
        @(negedge clk);
        rx_byte_vld = 0; rx_sof = 0; rx_eof = 0;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(!tx_halt && !irq_len_err && !rx_sts_vld && !rx_sts_len_err && !rx_wr_en,
            "R1 reset state", int'({tx_halt, irq_len_err, rx_sts_vld, rx_wr_en}), 0);

        max_len = 11'd8;
        send_tx(8, "R2 at-limit frame no halt");
        send_tx(6, "R8 short frame 1");
        send_tx(6, "R8 short frame 2 no accumulation");
        send_tx(9, "R2 limit+1 halts");
        chk(irq_len_err == 1, "R4 irq set with halt", int'(irq_len_err), 1);

        // bytes during halt ignored, halt stays
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tx_byte_vld = 1; tx_sof = (i == 0);
        end
        @(negedge clk); tx_byte_vld = 0; tx_sof = 0;
        #1 chk(tx_halt == 1, "R3 halt holds through bytes", int'(tx_halt), 1);

        pulse(irq_clr); #1;
        chk(irq_len_err == 0, "R4 irq cleared by strobe", int'(irq_len_err), 0);
        chk(tx_halt == 1, "R3 halt unaffected by irq_clr", int'(tx_halt), 1);

        pulse(tx_restart); #1;
        chk(tx_halt == 0, "R3 restart clears halt", int'(tx_halt), 0);
        send_tx(8, "R3 counter cleared, full frame ok");

        send_tx(10, "R2 second overrun");
        pulse(tx_restart); #1;
        chk(irq_len_err == 1, "R4 irq survives restart", int'(irq_len_err), 1);

        // overrun and clear strobe in the same cycle: set wins
        @(negedge clk); irq_clr = 1; pulse(irq_clr); #1;
        chk(irq_len_err == 0, "R4 irq cleared", int'(irq_len_err), 0);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); tx_byte_vld = 1; tx_sof = (i == 0); irq_clr = (i == 8);
        end
        @(negedge clk); tx_byte_vld = 0; tx_sof = 0; irq_clr = 0;
        #1 chk(irq_len_err == 1, "R4 set beats clear", int'(irq_len_err), 1);
        pulse(tx_restart);
        pulse(irq_clr);

        // receive
        send_rx(5, "R5 short frame gate");
        send_rx(8, "R5 at-limit gate");
        send_rx(12, "R5 overlong gate closes");
        send_rx(3, "R7 frame after overrun written");
        max_len = 11'd1;
        send_rx(1, "R6 single-byte frame a");
        send_rx(1, "R6 single-byte frame b");
        max_len = 11'd0;
        send_rx(2, "R9 zero limit never writes");
        send_tx(1, "R9 zero limit halts tx");
        pulse(tx_restart);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all statuses reported", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                chk(0, "watchdog expired", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule